// File: doc/BRIEF.md
# Legacy memory region attribute decoder

This block routes each memory access either to internal DRAM or out to the external bus. Below 1 MB it applies per-segment read and write attributes across the upper legacy area. It also applies an enable for the video hole. A programmable management-RAM window can pull management-mode accesses inside it to internal memory wherever the window sits.

Configuration goes through a single-cycle write port. Twelve byte-wide selectors cover seven attribute registers, a video control byte, two window base bytes, a window size byte and a window control byte. A combinational read port returns the masked stored value of the selected byte.

The access decode is purely combinational. It works from the registered configuration and a top-of-memory input. For every valid access it raises exactly one of two route outputs.

Top module: `legacy_route_dec`

## Requirements
- R1: An attribute register (selector 0 to 6) stores the written byte ANDed with 0x33, and reads of it return that masked value.
- R2: For a read access (acc_write = 0) in an attribute-controlled segment, bit 0 (low field) or bit 4 (high field) of the register set routes the access internally; when that bit is clear, the access goes external.
- R3: For a write access (acc_write = 1) in an attribute-controlled segment, bit 1 (low field) or bit 5 (high field) of the register set routes the access internally; when that bit is clear, the access goes external.
- R4: Attribute register 0 has two fields. Its low field covers 0x80000-0x9FFFF and its high field covers 0xF0000-0xFFFFF. Registers 1 to 6 each cover two consecutive 16 KB segments, rising from 0xC0000, and within each register the low field takes the lower segment. Register 1 therefore covers 0xC0000 and 0xC4000, and register 6 covers 0xE8000 and 0xEC000.
- R5: When bit 1 of the video control byte (selector 7) is set, 0xA0000-0xBFFFF routes internally for reads and writes. When that bit is clear, the range goes external. Only bit 1 of the byte is stored.
- R6: The window base is formed from selector 8, which supplies address bits 23:16, and selector 9, which supplies address bits 31:24. The window size is (upper nibble of selector 10 + 1) x 64 KB. Only the upper nibble of selector 10 is stored.
- R7: The window is active only when the base is nonzero and bit 3 of selector 11 is set. Only bit 3 of selector 11 is stored.
- R8: A management-mode access (acc_smm = 1) inside an active window routes internally. An access without the flag, or outside the window, follows the normal decode.
- R9: An access that falls in no legacy region routes internally when its address is below tom and externally otherwise.
- R10: While acc_valid is high, exactly one of route_int and route_ext is high. While acc_valid is low, both are low.
- R11: After reset, every stored configuration byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration byte selector (0-11) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Masked value of the selected byte |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_smm | input | 1 | Access is in management mode |
| tom | input | 32 | Top of internal memory |
| route_int | output | 1 | Access goes to internal DRAM |
| route_ext | output | 1 | Access goes to the external bus |

## Verification
The hardest case to reach is a management window that overlaps a legacy attribute segment. Both decoders claim the same address there, and only the mode flag separates the two outcomes. The stimulus first closes the segment's attributes. It then places a 64 KB window base on 0xC0000 and enables the window. Finally it issues the same read with and without the flag. A second hard case is the window's zero-base rule, which the bench reaches by clearing the base bytes while the enable bit stays set and tom is zero, so that only the window could route internally.

// File: rtl/legacy_route_dec.sv
module legacy_route_dec #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_sel,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_write,
  input  logic          acc_smm,
  input  logic [AW-1:0] tom,
  output logic          route_int,
  output logic          route_ext
);
  localparam int NATTR = 7;

  logic [7:0] attr [NATTR];
  logic       vid_en;
  logic [7:0] base_lo, base_hi;
  logic [3:0] size_nib;
  logic       win_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NATTR; i++) attr[i] <= '0;
      vid_en   <= 1'b0;
      base_lo  <= '0;
      base_hi  <= '0;
      size_nib <= '0;
      win_en   <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        4'd7:    vid_en   <= cfg_wdata[1];
        4'd8:    base_lo  <= cfg_wdata;
        4'd9:    base_hi  <= cfg_wdata;
        4'd10:   size_nib <= cfg_wdata[7:4];
        4'd11:   win_en   <= cfg_wdata[3];
        default: if (cfg_sel < 4'd7) attr[cfg_sel[2:0]] <= cfg_wdata & 8'h33;
      endcase
    end
  end

  always_comb begin
    case (cfg_sel)
      4'd7:    cfg_rdata = {6'd0, vid_en, 1'b0};
      4'd8:    cfg_rdata = base_lo;
      4'd9:    cfg_rdata = base_hi;
      4'd10:   cfg_rdata = {size_nib, 4'd0};
      4'd11:   cfg_rdata = {4'd0, win_en, 3'd0};
      default: cfg_rdata = (cfg_sel < 4'd7) ? attr[cfg_sel[2:0]] : 8'h00;
    endcase
  end

  // management window
  logic [AW:0] win_base, win_top, addr_x;
  logic        win_act, win_hit;
  assign win_base = {1'b0, {(AW-32){1'b0}}, base_hi, base_lo, 16'h0000};
  assign win_top  = win_base + ({{(AW-20){1'b0}}, size_nib, 16'h0000} + (AW+1)'(32'h0001_0000));
  assign addr_x   = {1'b0, acc_addr};
  assign win_act  = win_en && ({base_hi, base_lo} != 16'h0000);
  assign win_hit  = (addr_x >= win_base) && (addr_x < win_top);

  // legacy region decode
  logic       below_1m, in_region, vid_seg;
  logic [5:0] seg;
  logic [2:0] areg;
  logic       ahigh;
  logic [1:0] fld;
  logic       norm_int, internal;

  assign below_1m = (acc_addr[AW-1:20] == '0);
  assign seg      = acc_addr[19:14];
  assign vid_seg  = below_1m && (seg[5:3] == 3'b101);

  always_comb begin
    in_region = below_1m && seg[5];
    areg  = 3'd0;
    ahigh = 1'b0;
    fld   = 2'b00;
    if (seg[5:3] == 3'b100) begin
      areg = 3'd0; ahigh = 1'b0;
    end else if (seg[5:2] == 4'b1111) begin
      areg = 3'd0; ahigh = 1'b1;
    end else if (seg[5:4] == 2'b11) begin
      areg  = seg[3:1] + 3'd1;
      ahigh = seg[0];
    end
    if (vid_seg) fld = {vid_en, vid_en};
    else         fld = ahigh ? attr[areg][5:4] : attr[areg][1:0];
  end

  assign norm_int  = in_region ? (acc_write ? fld[1] : fld[0]) : (acc_addr < tom);
  assign internal  = (win_act && win_hit && acc_smm) || norm_int;
  assign route_int = acc_valid && internal;
  assign route_ext = acc_valid && !internal;

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $countones({route_int, route_ext}) == 1); // R10
  AST_NO_ROUTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !route_int && !route_ext); // R10
  AST_ATTR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel < 4'd7) |=> attr[$past(cfg_sel[2:0])] == ($past(cfg_wdata) & 8'h33)); // R1
  AST_VIDEO_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && vid_seg && vid_en) |-> route_int); // R5
  AST_SMM_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_smm && win_act && win_hit) |-> route_int); // R8
  AST_ABOVE_TOM_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !below_1m && acc_addr >= tom && !(win_act && win_hit && acc_smm)) |-> route_ext); // R9
endmodule

// File: tb/tb_legacy_route_dec.sv
`timescale 1ns/1ps
module tb_legacy_route_dec;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_sel = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [7:0]  cfg_rdata;
  logic        acc_valid = 0;
  logic [31:0] acc_addr = 0;
  logic        acc_write = 0;
  logic        acc_smm = 0;
  logic [31:0] tom = 32'h0100_0000;
  logic        route_int, route_ext;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  legacy_route_dec dut (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(string req, input logic [3:0] s, input logic [7:0] e);
    cfg_sel = s; #1; chk(req, {24'd0, cfg_rdata}, {24'd0, e});
  endtask

  task automatic acc(string req, input logic [31:0] a, input logic w, input logic sm, input logic exp_int);
    @(negedge clk); acc_valid = 1; acc_addr = a; acc_write = w; acc_smm = sm; #1;
    chk(req, {30'd0, route_int, route_ext}, {30'd0, exp_int, !exp_int});
    @(negedge clk); acc_valid = 0;
  endtask

  task automatic t_reset;
    for (int s = 0; s < 12; s++) rd("R11 reset readback", 4'(s), 8'h00);
    acc("R11 reset attr closed", 32'h000C_0000, 0, 0, 0);
  endtask

  task automatic t_mask;
    wr(3, 8'hFF); rd("R1 mask ff", 3, 8'h33);
    wr(3, 8'hCC); rd("R1 mask cc", 3, 8'h00);
  endtask

  task automatic t_rw;
    wr(1, 8'h01);
    acc("R2 read int", 32'h000C_0000, 0, 0, 1);
    acc("R3 write ext", 32'h000C_0000, 1, 0, 0);
    wr(1, 8'h02);
    acc("R2 read ext", 32'h000C_3FFF, 0, 0, 0);
    acc("R3 write int", 32'h000C_3FFF, 1, 0, 1);
  endtask

  task automatic t_map;
    wr(1, 8'h10);
    acc("R4 c4000 high field", 32'h000C_4000, 0, 0, 1);
    acc("R4 c0000 low field", 32'h000C_0000, 0, 0, 0);
    wr(6, 8'h30);
    acc("R4 ec000 write", 32'h000E_FFFF, 1, 0, 1);
    acc("R4 e8000 closed", 32'h000E_8000, 0, 0, 0);
    wr(0, 8'h13);
    acc("R4 9ffff low", 32'h0009_FFFF, 1, 0, 1);
    acc("R4 f0000 high read", 32'h000F_0000, 0, 0, 1);
    acc("R4 fffff high write", 32'h000F_FFFF, 1, 0, 0);
    acc("R9 7ffff default", 32'h0007_FFFF, 0, 0, 1);
    wr(1, 8'h00);
  endtask

  task automatic t_video;
    acc("R5 video off", 32'h000A_0000, 0, 0, 0);
    wr(7, 8'hFF); rd("R5 video mask", 7, 8'h02);
    acc("R5 video on read", 32'h000A_0000, 0, 0, 1);
    acc("R5 video on write", 32'h000B_FFFF, 1, 0, 1);
    wr(7, 8'h00);
  endtask

  task automatic t_tom;
    acc("R9 below tom", 32'h00FF_FFFF, 1, 0, 1);
    acc("R9 at tom", 32'h0100_0000, 0, 0, 0);
    acc("R9 low default", 32'h0005_0000, 0, 0, 1);
  endtask

  task automatic t_window;
    wr(8, 8'h00); wr(9, 8'h02); wr(10, 8'h1F);
    rd("R6 size mask", 10, 8'h10); rd("R6 base hi", 9, 8'h02);
    acc("R7 window disabled", 32'h0200_0000, 0, 1, 0);
    wr(11, 8'hFF); rd("R7 ctl mask", 11, 8'h08);
    acc("R8 smm in window", 32'h0200_0000, 0, 1, 1);
    acc("R6 last byte of 128K", 32'h0201_FFFF, 1, 1, 1);
    acc("R6 past window", 32'h0202_0000, 0, 1, 0);
    acc("R8 no smm flag", 32'h0200_0000, 0, 0, 0);
    wr(9, 8'h00); wr(8, 8'h0C); wr(10, 8'h00);
    acc("R8 smm over legacy seg", 32'h000C_0000, 0, 1, 1);
    acc("R8 non smm legacy seg", 32'h000C_0000, 0, 0, 0);
    acc("R6 64K window end", 32'h000D_0000, 0, 1, 0);
    wr(8, 8'h00); tom = 32'h0;
    acc("R7 zero base inactive", 32'h0000_0000, 0, 1, 0);
    tom = 32'h0100_0000;
  endtask

  task automatic t_idle;
    @(negedge clk); acc_valid = 0; acc_addr = 32'h000A_0000; #1;
    chk("R10 idle no route", {30'd0, route_int, route_ext}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_mask; t_rw; t_map; t_video; t_tom; t_window; t_idle;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule